// File: doc/BRIEF.md
# RTC Seconds Tick Divider

This block turns a real-time-clock source into a once-per-second calendar tick. It uses two divider stages in series. The first stage is a 7-bit prescaler. It produces a pre-tick every `pre_div_i + 1` enabled source cycles. The second stage is a 15-bit down counter that steps once per pre-tick. When it is already at zero, the next pre-tick reloads it from `sec_div_i` and raises the seconds tick. The second-stage count is visible on `frac_o` and shows how much of the current second is still to go, in pre-tick units.

The seconds rate is the source rate divided by `(pre_div_i + 1) * (sec_div_i + 1)`. For a given seconds rate, software should pick the largest prescale factor it can. Fewer enabled cycles then reach the wider second stage, which saves switching power. Each stage captures its divide factor only when it reloads, so factors can be rewritten at any time without cutting a period short. Reset is active-low and synchronous to the source clock. While it is held, each clock edge loads both stages from their factor inputs.

There is no data stream at this block's edge. The ticks are plain one-cycle strobes, and they have no back-pressure: a receiver must take each strobe in the cycle it is high.

Top module: `rtc_tick_divider`

## Requirements
- R1: While `rst_ni` is low, each rising clock edge loads the prescaler with `pre_div_i` and the fraction counter with `sec_div_i`, and drives `pre_tick_o` and `sec_tick_o` low. After such an edge, `frac_o` equals `sec_div_i`.
- R2: With `en_i` held high and the factor fixed at P, `pre_tick_o` is high in exactly one cycle out of every P+1. This includes P = 127.
- R3: `frac_o` changes only in a cycle where `pre_tick_o` is high. In such a cycle, unless it is a reload, the new value is one less than the previous value.
- R4: A pre-tick that finds `frac_o` at zero reloads it from `sec_div_i`. In the cycle `frac_o` shows the reloaded value, `sec_tick_o` and `pre_tick_o` are both high for that one cycle.
- R5: After reset is released, with factors P and S fixed and `en_i` high, the first `sec_tick_o` comes after exactly (P+1)*(S+1) clock edges. Every later one comes the same number of edges after the one before.
- R6: A new factor is used only from the next reload of its own stage. If both factors change from (P0,S0) to (P1,S1) in the cycle just after a seconds tick, the next second lasts (P0+1)+S0*(P1+1) enabled cycles. After that the seconds tick rate is (P1+1)*(S1+1), and each reload loads S1.
- R7: While `en_i` is low, both counters hold their values and both tick outputs stay low. Counting resumes from the held state, so disabled cycles do not count toward the period.
- R8: With both factors at zero and `en_i` high, `pre_tick_o` and `sec_tick_o` are high in every cycle and `frac_o` stays at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | RTC source clock |
| rst_ni | input | 1 | Active-low synchronous reset; loads both stages from the factor inputs |
| en_i | input | 1 | Count enable; both stages freeze while low |
| pre_div_i | input | 7 | Prescaler divide factor P (divides by P+1) |
| sec_div_i | input | 15 | Fraction-stage divide factor S (divides by S+1) |
| pre_tick_o | output | 1 | One-cycle strobe per prescaler wrap |
| sec_tick_o | output | 1 | One-cycle strobe per second, when the fraction counter reloads |
| frac_o | output | 15 | Live fraction counter: pre-ticks left in the current second |

## Verification
The properties assume two things about the inputs. First, `en_i` is not low in the cycle just before reset is asserted. Second, `sec_div_i` stays stable during the last two clock edges of any reset pulse, so that the first cycle after release does not see a load that was made while reset was held. The stimulus meets both. It holds `en_i` high around every reset pulse. It changes factors during reset only when at least three reset edges still follow. Mid-run factor changes happen at the boundary of a second, so that the length of the transition second can be computed from R6.

// File: rtl/tickdiv_pkg.sv
package tickdiv_pkg;

  // What a divider stage does on the coming clock edge.
  typedef enum logic [1:0] {
    ACT_HOLD   = 2'd0,
    ACT_STEP   = 2'd1,
    ACT_RELOAD = 2'd2
  } act_e;

  // A stepped stage at zero wraps; otherwise it counts down.
  function automatic act_e pick_action(input logic step, input logic at_zero);
    if (!step) return ACT_HOLD;
    return at_zero ? ACT_RELOAD : ACT_STEP;
  endfunction

endpackage

// File: rtl/tickdiv_stage.sv
module tickdiv_stage #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic [W-1:0] factor_i,
  output logic [W-1:0] count_o,
  output logic         wrap_o
);
  import tickdiv_pkg::*;

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] count_q;
  act_e         act;

  always_comb act = pick_action(step_i, count_q == '0);

  assign wrap_o  = (act == ACT_RELOAD);
  assign count_o = count_q;

  // Factor is sampled only on reset or on wrap.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      count_q <= factor_i;
    end else begin
      case (act)
        ACT_STEP:   count_q <= count_q - ONE;
        ACT_RELOAD: count_q <= factor_i;
        default:    count_q <= count_q;
      endcase
    end
  end

endmodule

// File: rtl/tickdiv_strobe_reg.sv
module tickdiv_strobe_reg #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk_i) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= d_i[i];
    end
    assign q_o[i] = q;
  end

endmodule

// File: rtl/rtc_tick_divider.sv
module rtc_tick_divider #(
  parameter int PRE_W = 7,
  parameter int SEC_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] pre_div_i,
  input  logic [SEC_W-1:0] sec_div_i,
  output logic             pre_tick_o,
  output logic             sec_tick_o,
  output logic [SEC_W-1:0] frac_o
);
  localparam int N_STROBE = 2;
  localparam int IDX_PRE  = 0;
  localparam int IDX_SEC  = 1;

  logic [PRE_W-1:0]    pre_count;
  logic                pre_wrap;
  logic                sec_wrap;
  logic [N_STROBE-1:0] strobe_d;
  logic [N_STROBE-1:0] strobe_q;

  // Stage one: prescaler stepped by every enabled source cycle.
  tickdiv_stage #(.W(PRE_W)) u_pre (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (en_i),
    .factor_i (pre_div_i),
    .count_o  (pre_count),
    .wrap_o   (pre_wrap)
  );

  // Stage two: fraction-of-second counter stepped by prescaler wraps.
  tickdiv_stage #(.W(SEC_W)) u_frac (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (pre_wrap),
    .factor_i (sec_div_i),
    .count_o  (frac_o),
    .wrap_o   (sec_wrap)
  );

  assign strobe_d[IDX_PRE] = pre_wrap;
  assign strobe_d[IDX_SEC] = sec_wrap;

  // Registered strobes line up with the cycle the new count is visible.
  tickdiv_strobe_reg #(.N(N_STROBE)) u_strobe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (strobe_d),
    .q_o    (strobe_q)
  );

  assign pre_tick_o = strobe_q[IDX_PRE];
  assign sec_tick_o = strobe_q[IDX_SEC];

endmodule

// File: rtl/rtc_tick_divider_chk.sv
module rtc_tick_divider_chk #(
  parameter int PRE_W = 7,
  parameter int SEC_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [PRE_W-1:0] pre_div_i,
  input logic [SEC_W-1:0] sec_div_i,
  input logic             pre_tick_o,
  input logic             sec_tick_o,
  input logic [SEC_W-1:0] frac_o
);
  localparam logic [SEC_W-1:0] ONE = SEC_W'(1);

  AST_PRE_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_tick_o |-> $past(en_i)); // R2

  AST_FRAC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pre_tick_o |-> $stable(frac_o)); // R3

  AST_FRAC_STEP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_tick_o && !sec_tick_o) |-> ((frac_o + ONE) == $past(frac_o))); // R3

  AST_SEC_WITH_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> pre_tick_o); // R4

  AST_RELOAD_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> (($past(frac_o) == '0) && (frac_o == $past(sec_div_i)))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pre_tick_o && !sec_tick_o && $stable(frac_o))); // R7

  wire unused_ok = ^pre_div_i;

endmodule

bind rtc_tick_divider rtc_tick_divider_chk #(.PRE_W(PRE_W), .SEC_W(SEC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .pre_div_i  (pre_div_i),
  .sec_div_i  (sec_div_i),
  .pre_tick_o (pre_tick_o),
  .sec_tick_o (sec_tick_o),
  .frac_o     (frac_o)
);

// File: tb/rtc_tick_divider_tb.sv
module rtc_tick_divider_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b1;
  logic [6:0]  pre_div = 7'd3;
  logic [14:0] sec_div = 15'd4;
  logic        pre_tick;
  logic        sec_tick;
  logic [14:0] frac;

  always #5 clk = ~clk;

  rtc_tick_divider u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .pre_div_i  (pre_div),
    .sec_div_i  (sec_div),
    .pre_tick_o (pre_tick),
    .sec_tick_o (sec_tick),
    .frac_o     (frac)
  );

  typedef struct {
    int    len;
    int    rel;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   pops = 0;
  bit   finished = 1'b0;

  // monitor state
  int   gap = 0;
  int   a_gap = 0;
  bit   a_chk = 1'b0;
  int   a_exp = 0;
  int   last_frac = 0;
  bit   en_last = 1'b0;
  bit   rst_last = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_sec(input int len, input int rel, input string tag, input int n);
    for (int i = 0; i < n; i++) q.push_back('{len, rel, tag});
  endtask

  // Monitor: samples on the falling edge, one half period after each update.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_last && en_last) begin
        gap++;
        a_gap++;
      end
      if (!rst_n) begin
        gap = 0;
        a_gap = 0;
      end else begin
        if (rst_last && !en_last) begin
          chk(!pre_tick && !sec_tick, "R7 ticks while disabled", int'(pre_tick) + int'(sec_tick), 0);
          chk(int'(frac) == last_frac, "R7 fraction held", int'(frac), last_frac);
        end
        if (sec_tick) begin
          chk(pre_tick, "R4 seconds tick with pre tick", int'(pre_tick), 1);
          if (q.size() == 0) begin
            chk(1'b0, "R5 unexpected seconds tick", gap, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            chk(gap == e.len, {e.tag, " seconds period"}, gap, e.len);
            chk(int'(frac) == e.rel, "R4 reload value", int'(frac), e.rel);
            pops++;
          end
          gap = 0;
        end
        if (pre_tick && !sec_tick && rst_last)
          chk(int'(frac) == last_frac - 1, "R3 fraction step", int'(frac), last_frac - 1);
        if (pre_tick) begin
          if (a_chk)
            chk(a_gap == a_exp, (a_exp == 1) ? "R8 pre tick every cycle" : "R2 pre tick period",
                a_gap, a_exp);
          a_gap = 0;
        end
      end
      last_frac = int'(frac);
      en_last   = en;
      rst_last  = rst_n;
    end
  end

  // Driver
  initial begin
    // R1: reset loads the factors
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(frac == 15'd4, "R1 reset load", int'(frac), 4);
    chk(!pre_tick && !sec_tick, "R1 ticks low in reset", int'(pre_tick) + int'(sec_tick), 0);
    @(posedge clk); #1;
    sec_div = 15'd6;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(frac == 15'd6, "R1 reset reload after factor change", int'(frac), 6);

    // R5: fixed factors, first second measured from release
    push_sec(28, 6, "R5", 3);
    a_exp = 4;
    a_chk = 1'b1;
    @(posedge clk); #1;
    rst_n = 1'b1;
    wait (pops == 3);

    // R7: enable gap in the middle of a second
    push_sec(28, 6, "R7", 1);
    repeat (9) @(posedge clk);
    #1 en = 1'b0;
    repeat (10) @(posedge clk);
    #1 en = 1'b1;
    wait (pops == 4);

    // R6: change both factors right after a seconds tick
    a_chk = 1'b0;
    pre_div = 7'd1;
    sec_div = 15'd2;
    push_sec(16, 2, "R6", 1);
    push_sec(6, 2, "R6", 2);
    wait (pops == 7);

    // R8: both factors zero
    pre_div = 7'd0;
    sec_div = 15'd0;
    push_sec(4, 0, "R6", 1);
    push_sec(1, 0, "R8", 4);
    wait (pops == 8);
    a_exp = 1;
    a_chk = 1'b1;
    wait (pops == 12);
    a_chk = 1'b0;

    // R2: largest prescale factor
    pre_div = 7'd127;
    sec_div = 15'd1;
    push_sec(1, 1, "R6", 1);
    push_sec(256, 1, "R5", 2);
    wait (pops == 13);
    a_exp = 128;
    a_chk = 1'b1;
    wait (pops == 15);
    a_chk = 1'b0;

    // R1 and R5: reset in the middle of a second
    pre_div = 7'd2;
    sec_div = 15'd2;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(frac == 15'd2, "R1 mid-run reset load", int'(frac), 2);
    chk(!pre_tick && !sec_tick, "R1 ticks low in mid-run reset", int'(pre_tick) + int'(sec_tick), 0);
    push_sec(9, 2, "R5", 2);
    a_exp = 3;
    a_chk = 1'b1;
    @(posedge clk); #1;
    rst_n = 1'b1;
    wait (pops == 17);
    repeat (3) @(posedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "R5 watchdog expired", pops, 17);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule